// File: doc/BRIEF.md
# Spare-Symbol Steering for a Two-Lane Memory Word

This block sits in a memory datapath on both sides of a pair of interleaved 72-bit DIMM lanes. Toward the pins it sits after the ECC encoder. Toward the decoder it sits after the pins. The 144-bit word is cut into 4-bit symbols, numbered from bit 0 upward, so symbol s occupies bits [4s+3:4s]. Lane 0 holds symbols 0 to 17 and lane 1 holds symbols 18 to 35.

The check code uses only three check symbols, which leaves one symbol free. That free symbol is split in half: two bits at the top of each lane, bits [71:70] and [143:142]. Symbols 17 and 35 hold those spare halves, so the code places no payload in the spare bits.

When scrubbing logic reports a failed chip position, the block takes its index. From the next cycle on, the block moves that symbol's four bits into the spare halves on writes and returns them to their place on reads, with no added cycle on either path. The first failure is absorbed without an alert. A later failure report raises a sticky predictive-failure flag for the lane that holds the reported symbol.

Top module: `sym_spare_steer`

## Requirements
- R1: After a synchronous reset, `spare_used` is 0, `spare_idx` is 0 and both `pfa_alert` bits are 0.
- R2: While `spare_used` is 0, `wr_data_out` equals `wr_data_in` except bits [71:70] and [143:142], which are 0. `rd_data_out` equals `rd_data_in`.
- R3: A `spare_req` pulse with a legal index while `spare_used` is 0 sets `spare_used` to 1 and `spare_idx` to that index after the clock edge. It raises no alert.
- R4: An index is legal when it is below 36 and is neither 17 nor 35, the two symbols that hold spare bits. A request with any other index changes nothing: no steering, no status change, no alert.
- R5: While steering is active with index k, `wr_data_out` has symbol k driven to 0. Bits [1:0] of `wr_data_in` symbol k go to bits [71:70], and bits [3:2] go to bits [143:142]. All other bits pass unchanged. The path is combinational.
- R6: While steering is active with index k, `rd_data_out` symbol k equals {`rd_data_in`[143:142], `rd_data_in`[71:70]}. All other bits, including the spare bits, pass unchanged. The path is combinational.
- R7: A request that arrives while `spare_used` is 1 never changes `spare_idx`, and steering stays on the first index.
- R8: A legal request while `spare_used` is 1 sets `pfa_alert[0]` if the index is below 18 and sets `pfa_alert[1]` otherwise, after the clock edge. The other bit is left as it was.
- R9: An alert bit stays at 1 until `alert_clr` is sampled high, and then goes to 0 after that edge. If a raise for a bit and `alert_clr` occur in the same cycle, the bit ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| spare_req | input | 1 | Single-cycle failure report from scrubbing |
| spare_req_idx | input | 6 | Index of the failed symbol |
| alert_clr | input | 1 | Synchronous clear of both alert bits |
| wr_data_in | input | 144 | Encoded word from the ECC encoder |
| wr_data_out | output | 144 | Word driven to the two DIMM lanes |
| rd_data_in | input | 144 | Word read from the two DIMM lanes |
| rd_data_out | output | 144 | Word passed to the ECC decoder |
| spare_used | output | 1 | Spare symbol is in use |
| spare_idx | output | 6 | Latched failed-symbol index |
| pfa_alert | output | 2 | Sticky predictive-failure flag per lane |

## Verification
A wrong latched index or a stray enable appears on the data paths in the same cycle. A write-read loop through a correct and a faulty model then disagrees in one symbol or in the four spare bits. A lost or wrongly routed alert shows on `pfa_alert` one edge after the second report. The bench therefore checks each status change at the first falling edge after the request. It checks the datapaths with several bit patterns, so that a bit landing in the wrong place is not hidden by a pattern that happens to match.

// File: rtl/sym_spare_pkg.sv
package sym_spare_pkg;

  // A symbol index is usable for sparing when it exists and does not
  // itself hold half of the spare symbol (last symbol of each lane).
  function automatic logic idx_is_legal(input int idx, input int nsym, input int lane_syms);
    return (idx < nsym) && ((idx % lane_syms) != (lane_syms - 1));
  endfunction

  // Lane that carries a given symbol index.
  function automatic int lane_of(input int idx, input int lane_syms);
    return idx / lane_syms;
  endfunction

endpackage

// File: rtl/sym_spare_ctrl.sv
module sym_spare_ctrl #(
  parameter int NSYM      = 36,
  parameter int LANE_SYMS = 18,
  parameter int LANES     = 2,
  parameter int IDX_W     = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic [IDX_W-1:0] req_idx,
  input  logic             clr,
  output logic             used,
  output logic [IDX_W-1:0] idx,
  output logic [LANES-1:0] alert
);
  import sym_spare_pkg::*;

  logic legal;
  int   req_lane;

  always_comb begin
    legal    = idx_is_legal(int'(req_idx), NSYM, LANE_SYMS);
    req_lane = lane_of(int'(req_idx), LANE_SYMS);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      used <= 1'b0;
      idx  <= '0;
    end else if (req && legal && !used) begin
      used <= 1'b1;
      idx  <= req_idx;
    end
  end

  // Raise takes priority over clear so that no report is lost.
  always_ff @(posedge clk) begin
    if (rst) begin
      alert <= '0;
    end else begin
      for (int l = 0; l < LANES; l++) begin
        if (req && legal && used && (req_lane == l)) begin
          alert[l] <= 1'b1;
        end else if (clr) begin
          alert[l] <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/sym_spare_wr.sv
module sym_spare_wr #(
  parameter int SYM_W  = 4,
  parameter int LANE_W = 72,
  parameter int LANES  = 2,
  parameter int IDX_W  = 6
) (
  input  logic                      en,
  input  logic [IDX_W-1:0]          idx,
  input  logic [LANES*LANE_W-1:0]   din,
  output logic [LANES*LANE_W-1:0]   dout
);
  localparam int WORD_W = LANES * LANE_W;
  localparam int NSYM   = WORD_W / SYM_W;
  localparam int HALF   = SYM_W / LANES;

  logic [SYM_W-1:0]  picked;
  logic [WORD_W-1:0] blanked;

  always_comb picked = din[int'(idx)*SYM_W +: SYM_W];

  // Zero the failed symbol in its original lane.
  for (genvar s = 0; s < NSYM; s++) begin : g_sym
    always_comb begin
      if (en && (idx == IDX_W'(s))) blanked[s*SYM_W +: SYM_W] = '0;
      else                          blanked[s*SYM_W +: SYM_W] = din[s*SYM_W +: SYM_W];
    end
  end

  // Each lane receives its share of the failed symbol in its top bits.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int TOP = l*LANE_W + LANE_W - 1;
    always_comb begin
      dout[TOP - HALF + 1 +: HALF] = en ? picked[l*HALF +: HALF] : '0;
    end
    if (l == 0) begin : g_low
      always_comb dout[TOP - HALF:0] = blanked[TOP - HALF:0];
    end else begin : g_mid
      always_comb dout[TOP - HALF:(l-1)*LANE_W + LANE_W] = blanked[TOP - HALF:(l-1)*LANE_W + LANE_W];
    end
  end

endmodule

// File: rtl/sym_spare_rd.sv
module sym_spare_rd #(
  parameter int SYM_W  = 4,
  parameter int LANE_W = 72,
  parameter int LANES  = 2,
  parameter int IDX_W  = 6
) (
  input  logic                      en,
  input  logic [IDX_W-1:0]          idx,
  input  logic [LANES*LANE_W-1:0]   din,
  output logic [LANES*LANE_W-1:0]   dout
);
  localparam int WORD_W = LANES * LANE_W;
  localparam int HALF   = SYM_W / LANES;

  logic [SYM_W-1:0] gathered;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_comb gathered[l*HALF +: HALF] = din[l*LANE_W + LANE_W - HALF +: HALF];
  end

  always_comb begin
    dout = din;
    if (en) dout[int'(idx)*SYM_W +: SYM_W] = gathered;
  end

endmodule

// File: rtl/sym_spare_steer.sv
module sym_spare_steer #(
  parameter int SYM_W  = 4,
  parameter int LANE_W = 72,
  localparam int LANES     = 2,
  localparam int WORD_W    = LANES * LANE_W,
  localparam int NSYM      = WORD_W / SYM_W,
  localparam int LANE_SYMS = LANE_W / SYM_W,
  localparam int IDX_W     = $clog2(NSYM)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spare_req,
  input  logic [IDX_W-1:0]  spare_req_idx,
  input  logic              alert_clr,
  input  logic [WORD_W-1:0] wr_data_in,
  output logic [WORD_W-1:0] wr_data_out,
  input  logic [WORD_W-1:0] rd_data_in,
  output logic [WORD_W-1:0] rd_data_out,
  output logic              spare_used,
  output logic [IDX_W-1:0]  spare_idx,
  output logic [LANES-1:0]  pfa_alert
);

  sym_spare_ctrl #(
    .NSYM(NSYM), .LANE_SYMS(LANE_SYMS), .LANES(LANES), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .req(spare_req), .req_idx(spare_req_idx),
    .clr(alert_clr), .used(spare_used), .idx(spare_idx), .alert(pfa_alert)
  );

  sym_spare_wr #(
    .SYM_W(SYM_W), .LANE_W(LANE_W), .LANES(LANES), .IDX_W(IDX_W)
  ) u_wr (
    .en(spare_used), .idx(spare_idx), .din(wr_data_in), .dout(wr_data_out)
  );

  sym_spare_rd #(
    .SYM_W(SYM_W), .LANE_W(LANE_W), .LANES(LANES), .IDX_W(IDX_W)
  ) u_rd (
    .en(spare_used), .idx(spare_idx), .din(rd_data_in), .dout(rd_data_out)
  );

endmodule

// File: rtl/sym_spare_steer_chk.sv
module sym_spare_steer_chk #(
  parameter int SYM_W  = 4,
  parameter int LANE_W = 72,
  localparam int WORD_W = 2 * LANE_W,
  localparam int IDX_W  = $clog2(WORD_W / SYM_W)
) (
  input logic              clk,
  input logic              rst,
  input logic              alert_clr,
  input logic [WORD_W-1:0] wr_data_in,
  input logic [WORD_W-1:0] wr_data_out,
  input logic [WORD_W-1:0] rd_data_in,
  input logic [WORD_W-1:0] rd_data_out,
  input logic              spare_used,
  input logic [IDX_W-1:0]  spare_idx,
  input logic [1:0]        pfa_alert
);
  localparam int HALF = SYM_W / 2;

  // R2: idle paths keep spare bits at zero and reads unchanged
  p_idle_paths_r2: assert property (@(posedge clk) disable iff (rst)
    !spare_used |-> (wr_data_out[LANE_W-1 -: HALF] == '0) &&
                    (wr_data_out[WORD_W-1 -: HALF] == '0) &&
                    (rd_data_out == rd_data_in));

  // R3: once in use, the spare stays in use
  p_used_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    spare_used |=> spare_used);

  // R5: the spare halves carry the failed symbol on writes
  p_wr_spare_r5: assert property (@(posedge clk) disable iff (rst)
    spare_used |-> {wr_data_out[WORD_W-1 -: HALF], wr_data_out[LANE_W-1 -: HALF]}
                   == wr_data_in[int'(spare_idx)*SYM_W +: SYM_W]);

  // R6: spare bits pass through the read path untouched
  p_rd_spare_pass_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_data_out[LANE_W-1 -: HALF] == rd_data_in[LANE_W-1 -: HALF]) &&
    (rd_data_out[WORD_W-1 -: HALF] == rd_data_in[WORD_W-1 -: HALF]));

  // R7: latched index frozen while spare in use
  p_idx_frozen_r7: assert property (@(posedge clk) disable iff (rst)
    spare_used |=> $stable(spare_idx));

  // R8: no alert can appear before the spare is consumed
  p_no_first_alert_r8: assert property (@(posedge clk) disable iff (rst)
    (!spare_used && (pfa_alert == 2'b00)) |=> (pfa_alert == 2'b00));

  // R9: alert bits hold until cleared
  p_alert0_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (pfa_alert[0] && !alert_clr) |=> pfa_alert[0]);
  p_alert1_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (pfa_alert[1] && !alert_clr) |=> pfa_alert[1]);

endmodule

bind sym_spare_steer sym_spare_steer_chk #(.SYM_W(SYM_W), .LANE_W(LANE_W)) u_chk (
  .clk(clk), .rst(rst), .alert_clr(alert_clr),
  .wr_data_in(wr_data_in), .wr_data_out(wr_data_out),
  .rd_data_in(rd_data_in), .rd_data_out(rd_data_out),
  .spare_used(spare_used), .spare_idx(spare_idx), .pfa_alert(pfa_alert)
);

// File: tb/sym_spare_steer_bench.sv
module sym_spare_steer_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         spare_req = 1'b0;
  logic [5:0]   spare_req_idx = '0;
  logic         alert_clr = 1'b0;
  logic [143:0] wr_data_in = '0;
  logic [143:0] wr_data_out;
  logic [143:0] rd_data_in = '0;
  logic [143:0] rd_data_out;
  logic         spare_used;
  logic [5:0]   spare_idx;
  logic [1:0]   pfa_alert;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sym_spare_steer u_sym_spare_steer (
    .clk(clk), .rst(rst), .spare_req(spare_req), .spare_req_idx(spare_req_idx),
    .alert_clr(alert_clr), .wr_data_in(wr_data_in), .wr_data_out(wr_data_out),
    .rd_data_in(rd_data_in), .rd_data_out(rd_data_out), .spare_used(spare_used),
    .spare_idx(spare_idx), .pfa_alert(pfa_alert)
  );

  localparam logic [143:0] PAT_A = {36{4'hA}} ^ {4{36'h0_1234_5678}};
  localparam logic [143:0] PAT_B = {9{16'hC3E1}};
  localparam logic [143:0] PAT_C = ~PAT_A;

  function automatic logic [143:0] exp_wr(input logic [143:0] x, input logic en, input int k);
    logic [143:0] r = x;
    logic [3:0]   s = x[k*4 +: 4];
    r[71:70]   = 2'b00;
    r[143:142] = 2'b00;
    if (en) begin
      r[k*4 +: 4] = 4'h0;
      r[71:70]    = s[1:0];
      r[143:142]  = s[3:2];
    end
    return r;
  endfunction

  function automatic logic [143:0] exp_rd(input logic [143:0] x, input logic en, input int k);
    logic [143:0] r = x;
    if (en) r[k*4 +: 4] = {x[143:142], x[71:70]};
    return r;
  endfunction

  task automatic check(input string req, input logic [143:0] act, input logic [143:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_status(input string req, input logic u, input int k, input logic [1:0] al);
    check({req, " spare_used"}, 144'(spare_used), 144'(u));
    check({req, " spare_idx"},  144'(spare_idx),  144'(k));
    check({req, " pfa_alert"},  144'(pfa_alert),  144'(al));
  endtask

  // Drive at a falling edge, let one rising edge pass, sample after the next fall.
  task automatic pulse_req(input int k, input logic clr);
    @(negedge clk);
    spare_req = 1'b1; spare_req_idx = 6'(k); alert_clr = clr;
    @(negedge clk);
    spare_req = 1'b0; alert_clr = 1'b0;
    #1;
  endtask

  task automatic pulse_clr();
    @(negedge clk);
    alert_clr = 1'b1;
    @(negedge clk);
    alert_clr = 1'b0;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
  endtask

  task automatic paths(input string rw, input string rr, input logic en, input int k);
    logic [143:0] pats [3] = '{PAT_A, PAT_B, PAT_C};
    foreach (pats[i]) begin
      wr_data_in = pats[i];
      rd_data_in = pats[(i + 1) % 3];
      #1;
      check(rw, wr_data_out, exp_wr(pats[i], en, k));
      check(rr, rd_data_out, exp_rd(pats[(i + 1) % 3], en, k));
    end
  endtask

  task automatic t_reset();
    do_reset();
    check_status("R1", 1'b0, 0, 2'b00);
  endtask

  task automatic t_idle();
    paths("R2 write idle", "R2 read idle", 1'b0, 0);
  endtask

  task automatic t_illegal();
    int bad [4] = '{36, 17, 35, 63};
    foreach (bad[i]) begin
      pulse_req(bad[i], 1'b0);
      check_status("R4 illegal index", 1'b0, 0, 2'b00);
    end
    paths("R4 write after illegal", "R4 read after illegal", 1'b0, 0);
  endtask

  task automatic t_first(input int k);
    pulse_req(k, 1'b0);
    check_status("R3 first failure", 1'b1, k, 2'b00);
    paths("R5 write steer", "R6 read steer", 1'b1, k);
  endtask

  task automatic t_second(input int k, input int hold, input logic [1:0] al);
    pulse_req(k, 1'b0);
    check_status("R8 second failure", 1'b1, hold, al);
    check("R7 index kept", 144'(spare_idx), 144'(hold));
    paths("R7 write still first", "R7 read still first", 1'b1, hold);
  endtask

  task automatic t_clear(input int hold);
    pulse_clr();
    check("R9 clear", 144'(pfa_alert), 144'(0));
    repeat (3) @(negedge clk);
    #1;
    check("R9 stays clear", 144'(pfa_alert), 144'(0));
    pulse_req(2, 1'b1);
    check("R9 raise beats clear", 144'(pfa_alert), 144'(2'b01));
    repeat (4) @(negedge clk);
    #1;
    check("R9 sticky", 144'(pfa_alert), 144'(2'b01));
    check("R7 index after raise", 144'(spare_idx), 144'(hold));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_idle();
    t_illegal();
    t_first(5);
    t_second(20, 5, 2'b10);
    t_second(3, 5, 2'b11);
    pulse_req(40, 1'b0);
    check("R4 illegal while used", 144'(pfa_alert), 144'(2'b11));
    t_clear(5);
    t_reset();
    t_first(30);
    t_second(0, 30, 2'b01);
    t_reset();
    t_first(0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule